// File: doc/BRIEF.md
# Software Flow-Control Transmit Gate

This block gives a UART transmitter in-band flow control driven by the received data stream. Every character the receiver delivers is compared with two programmable values, a pause character and a release character. A pause match withdraws the transmit permission and a release match restores it. The block only observes the receive stream: matched characters still flow on to the receive path unchanged.

The transmit-permit output is meant to be sampled by the transmitter's load logic at the instant it would start a new character. A character already being shifted is never cut short. When a pause arrives while a character is in flight, the gate records a draining phase. That phase settles to a full halt when the transmitter reports the character done, or when it is already idle. The gate acts only when the 3-bit mode field selects software flow control. In every other mode the permit is held high and any pause is forgotten.

Top module: `swfc_tx_gate`

## Requirements
- R1: After reset `tx_permit` is 1.
- R2: With `fc_mode` equal to 3'b010, a cycle with `rx_valid` high and `rx_byte` equal to `pause_char` makes `tx_permit` 0 from the next clock edge on.
- R3: With `fc_mode` equal to 3'b010 and the gate paused, a cycle with `rx_valid` high and `rx_byte` equal to `release_char` (and not equal to `pause_char`) makes `tx_permit` 1 from the next clock edge on.
- R4: While `fc_mode` is not 3'b010, `tx_permit` is 1 and received characters have no effect. A pause held when the mode leaves 3'b010 is cleared, so `tx_permit` is 1 when the mode returns to 3'b010.
- R5: When `pause_char` equals `release_char`, a matching character is treated as a pause.
- R6: A pause character while already paused, or a release character while already running, leaves `tx_permit` unchanged.
- R7: Characters that match neither value, and cycles with `rx_valid` low, leave `tx_permit` unchanged.
- R8: A pause that arrives while `tx_busy` is high keeps `tx_permit` at 0 through the cycle in which `tx_done` is reported and afterwards. The character in flight completes and no further character is permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_mode | input | 3 | Flow-control mode; 3'b010 enables this gate |
| pause_char | input | 8 | Programmed pause character |
| release_char | input | 8 | Programmed release character |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_byte | input | 8 | Received character |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_done | input | 1 | Transmitter finished a character this cycle |
| tx_permit | output | 1 | Transmitter may start a new character |

## Verification
The stream of received bytes is drawn from a small alphabet, so pause matches, release matches and non-matches all occur often. It is mixed with random busy/done activity and occasional mode changes. Matches separate correct decoding and priority from stray effects of non-matching bytes. Mode changes expose whether a stale pause survives leaving software flow control. Directed cases cover equal pause/release values, repeated pause and release characters, and a pause during a busy character followed by its done pulse. The last case tells the draining phase apart from a premature release.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int CHAR_W = 8;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_SWFC = 3'b010;

  typedef enum logic [1:0] {
    GATE_RUN   = 2'd0,
    GATE_DRAIN = 2'd1,
    GATE_HALT  = 2'd2
  } gate_state_e;

  typedef struct packed {
    logic pause_hit;
    logic release_hit;
  } match_t;

  function automatic logic mode_is_swfc(input logic [MODE_W-1:0] m);
    return m == MODE_SWFC;
  endfunction

  // pause wins over release when both values are equal
  function automatic match_t classify(input logic [CHAR_W-1:0] b,
                                      input logic [CHAR_W-1:0] p,
                                      input logic [CHAR_W-1:0] r);
    match_t res;
    res.pause_hit   = (b == p);
    res.release_hit = (b == r) && (b != p);
    return res;
  endfunction
endpackage

// File: rtl/swfc_char_match.sv
module swfc_char_match
  import swfc_pkg::*;
#(
  parameter int W = CHAR_W
) (
  input  logic         strobe,
  input  logic         enable,
  input  logic [W-1:0] data,
  input  logic [W-1:0] pause_val,
  input  logic [W-1:0] release_val,
  output logic         pause_evt,
  output logic         release_evt
);
  match_t m;
  always_comb begin
    m           = classify(data, pause_val, release_val);
    pause_evt   = strobe && enable && m.pause_hit;
    release_evt = strobe && enable && m.release_hit;
  end

  always_comb begin
    assert (!(pause_evt && release_evt)); // R5
  end
endmodule

// File: rtl/swfc_gate_fsm.sv
module swfc_gate_fsm
  import swfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pause_evt,
  input  logic release_evt,
  input  logic tx_busy,
  input  logic tx_done,
  output logic permit
);
  gate_state_e state_q, state_d;
  logic        at_boundary;

  assign at_boundary = tx_done || !tx_busy;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = GATE_RUN;
    end else begin
      case (state_q)
        GATE_RUN:   if (pause_evt) state_d = at_boundary ? GATE_HALT : GATE_DRAIN;
        GATE_DRAIN: if (release_evt) state_d = GATE_RUN;
                    else if (at_boundary) state_d = GATE_HALT;
        GATE_HALT:  if (release_evt) state_d = GATE_RUN;
        default:    state_d = GATE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GATE_RUN;
    else        state_q <= state_d;
  end

  assign permit = !enable || (state_q == GATE_RUN);

  AST_PAUSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pause_evt) |=> (!permit || !enable)); // R2
  AST_RELEASE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && release_evt) |=> permit); // R3
  AST_MODE_OFF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> permit); // R4
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GATE_DRAIN && enable && !release_evt) |=> (!permit || !enable)); // R8
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !pause_evt && !release_evt) ##1 enable |-> $stable(permit)); // R7
endmodule

// File: rtl/swfc_tx_gate.sv
module swfc_tx_gate
  import swfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] fc_mode,
  input  logic [CHAR_W-1:0] pause_char,
  input  logic [CHAR_W-1:0] release_char,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic              tx_busy,
  input  logic              tx_done,
  output logic              tx_permit
);
  logic swfc_on;
  logic pause_evt;
  logic release_evt;

  assign swfc_on = mode_is_swfc(fc_mode);

  swfc_char_match #(.W(CHAR_W)) u_match (
    .strobe      (rx_valid),
    .enable      (swfc_on),
    .data        (rx_byte),
    .pause_val   (pause_char),
    .release_val (release_char),
    .pause_evt   (pause_evt),
    .release_evt (release_evt)
  );

  swfc_gate_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (swfc_on),
    .pause_evt   (pause_evt),
    .release_evt (release_evt),
    .tx_busy     (tx_busy),
    .tx_done     (tx_done),
    .permit      (tx_permit)
  );

  AST_RESET_OPEN: assert property (@(posedge clk)
    !rst_n |=> (tx_permit || !rst_n)); // R1
endmodule

// File: tb/test_swfc_tx_gate.sv
module test_swfc_tx_gate;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] fc_mode = 3'b010;
  logic [7:0] pause_char = 8'h13, release_char = 8'h11;
  logic       rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic       tx_busy = 0, tx_done = 0;
  logic       tx_permit;

  int errors = 0, checks = 0;
  bit exp_paused = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swfc_tx_gate i_swfc_tx_gate (.*);

  function automatic bit model_next(bit paused, logic [2:0] m, bit v,
                                    logic [7:0] b, logic [7:0] p, logic [7:0] r);
    if (m != 3'b010) return 0;
    if (v && b == p) return 1;
    if (v && b == r) return 0;
    return paused;
  endfunction

  task automatic check(string req, bit exp);
    checks++;
    if (tx_permit !== exp) begin
      errors++;
      $display("FAIL %s: tx_permit=%b expected=%b", req, tx_permit, exp);
    end
  endtask

  // inputs set at negedge, clock edge, model update, sample at next negedge
  task automatic step(string req, logic [2:0] m, bit v, logic [7:0] b,
                      bit busy, bit done);
    fc_mode = m; rx_valid = v; rx_byte = b; tx_busy = busy; tx_done = done;
    exp_paused = model_next(exp_paused, m, v, b, pause_char, release_char);
    @(negedge clk);
    check(req, !(fc_mode == 3'b010 && exp_paused));
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    errors++; checks++;
    $display("FAIL watchdog: expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    check("R1", 1'b1);
    rst_n = 1;
    @(negedge clk);
    check("R1", 1'b1);

    step("R7", 3'b010, 1, 8'h41, 0, 0);
    step("R2", 3'b010, 1, 8'h13, 0, 0);
    step("R6", 3'b010, 1, 8'h13, 0, 0);
    step("R7", 3'b010, 0, 8'h11, 0, 0);
    step("R3", 3'b010, 1, 8'h11, 0, 0);
    step("R6", 3'b010, 1, 8'h11, 0, 0);
    // pause during busy character, then done pulse
    step("R8", 3'b010, 1, 8'h13, 1, 0);
    step("R8", 3'b010, 0, 8'h00, 1, 0);
    step("R8", 3'b010, 0, 8'h00, 1, 1);
    step("R8", 3'b010, 0, 8'h00, 0, 0);
    // leave mode while paused, inputs ignored, return open
    step("R4", 3'b000, 0, 8'h00, 0, 0);
    step("R4", 3'b001, 1, 8'h13, 0, 0);
    step("R4", 3'b010, 0, 8'h00, 0, 0);
    // identical values
    release_char = 8'h13;
    step("R5", 3'b010, 1, 8'h13, 0, 0);
    step("R5", 3'b010, 1, 8'h13, 0, 0);
    release_char = 8'h11;
    step("R3", 3'b010, 1, 8'h11, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] b;
      logic [2:0] m;
      int sel = $urandom_range(0, 3);
      b = (sel == 0) ? pause_char : (sel == 1) ? release_char : 8'($urandom);
      m = ($urandom_range(0, 15) == 0) ? 3'($urandom) : 3'b010;
      step("R2/R3 random", m, $urandom_range(0, 1) == 1, b,
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule